// File: doc/BRIEF.md
# Warp Matrix Fragment Loader

This block performs one collective load of one, two or four 8x8 matrices of 16-bit elements for a group of 32 lanes. Each lane supplies one byte address. The address of lane j gives the start of row j%8 of matrix j/8. Rows are read one at a time from a scratchpad that has a 128-bit read port and one cycle of read latency. The elements of each row are then spread across the lanes. Each lane ends up with one 32-bit fragment register per matrix, and register k of every lane holds a fragment of matrix k.

A request is a single `start` pulse that carries the matrix count, a transpose flag and the 32 lane addresses. All three are captured when the request is accepted. While it runs, the block owns the scratchpad read port. It finishes with a one-cycle `done` pulse, and at that point the lane registers for the request are complete. The rows of a matrix may lie anywhere in the scratchpad, so every row is fetched through its own lane address.

Top module: `warp_frag_loader`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `memRdEn` are low and every lane register reads zero.
- R2: `matCount` encodes the number of matrices: 2'b00 means one, 2'b01 means two, and 2'b10 or 2'b11 both mean four. A request issues exactly 8 row reads per matrix, one per cycle, on consecutive cycles.
- R3: Row reads are issued in order of lane index, starting at lane 0. Read n uses the address captured from lane n.
- R4: Without transpose, let e[c] be the 16-bit element at scratchpad bits [16c+15:16c] of row r of matrix k. Lane i then gets, in register k, e[2*(i%4)] in bits [15:0] and e[2*(i%4)+1] in bits [31:16], where r = i/4.
- R5: With transpose, register k of lane i gets element (row 2*(i%4), column i/4) of matrix k in bits [15:0] and element (row 2*(i%4)+1, column i/4) in bits [31:16].
- R6: A good request clears every lane register beyond the requested matrix count to zero.
- R7: When a request of N rows is accepted at clock edge E0, `done` is high for exactly one cycle, the cycle after edge E0+N+1.
- R8: If any used lane address has a nonzero value in bits [3:0], the request makes no row reads. `done` rises in the cycle after the accepting edge, `err` is high with it, and the lane registers keep their earlier contents. `err` stays high until the next accepted request.
- R9: Addresses of lanes that are not used by the requested matrix count are never checked for alignment.
- R10: A `start` pulse that arrives while `busy` is high is ignored. It does not change the reads, the timing or the result of the request in progress, even if the inputs change at the same time.
- R11: `busy` is high from the cycle after an accepting edge through the `done` cycle, and low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| matCount | input | 2 | Matrix count code |
| transpose | input | 1 | Column-major placement select |
| rowAddr | input | 32*ADDR_W | Lane addresses, lane j in bits [j*ADDR_W +: ADDR_W] |
| memRdEn | output | 1 | Scratchpad read strobe |
| memRdAddr | output | ADDR_W | Scratchpad byte address of the row |
| memRdData | input | 8*ELEM_W | Row data, valid the cycle after the strobe |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Misaligned-address indication |
| laneRegs | output | 32*4*2*ELEM_W | Register k of lane i at index (i*4+k) |

## Verification
The hardest case to reach is a second `start` that arrives in the middle of a fetch while the addresses, count and transpose inputs are changing. That stimulus is only rejected correctly if the captured copy fully isolates the request in progress. The bench raises `start` partway through a load, flips the transpose input and scrambles every lane address at the same moment. It then checks that the read sequence, the done timing and all 128 lane registers still match the original request. Misaligned addresses are placed both in used and in unused lanes, so that the error path and its masking are each exercised.

// File: rtl/wmfl_pkg.sv
package wmfl_pkg;
  localparam int LANES     = 32;
  localparam int ROWS      = 8;
  localparam int MAX_MATS  = 4;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam int ROW_IDX_W  = $clog2(ROWS);
  localparam int MAT_IDX_W  = $clog2(MAX_MATS);
  localparam int ALIGN_BITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DRAIN,
    ST_DONE
  } ldState_e;

  typedef struct packed {
    logic                 clr;
    logic                 wrEn;
    logic                 trans;
    logic [MAT_IDX_W-1:0] matIdx;
    logic [ROW_IDX_W-1:0] rowIdx;
  } fragStrobe_t;
endpackage

// File: rtl/wmfl_ctrl.sv
module wmfl_ctrl
  import wmfl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [1:0]              matCount,
  input  logic                    transIn,
  input  logic [LANES*ADDR_W-1:0] rowAddr,
  output logic                    memRdEn,
  output logic [ADDR_W-1:0]       memRdAddr,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output fragStrobe_t             strobe
);
  localparam int CNT_W = LANE_IDX_W;

  ldState_e                 state;
  logic [LANES-1:0][ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]         cnt;
  logic [CNT_W-1:0]         lastQ;
  logic                     transQ;
  logic                     pendValid;
  logic [CNT_W-1:0]         pendIdx;
  logic                     errQ;

  logic                     accept;
  logic                     badAddr;
  logic [CNT_W:0]           reqRows;

  always_comb begin
    case (matCount)
      2'b00:   reqRows = (CNT_W+1)'(ROWS);
      2'b01:   reqRows = (CNT_W+1)'(2*ROWS);
      default: reqRows = (CNT_W+1)'(4*ROWS);
    endcase
  end

  always_comb begin
    badAddr = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if ((CNT_W+1)'(l) < reqRows && |rowAddr[l*ADDR_W +: ALIGN_BITS])
        badAddr = 1'b1;
    end
  end

  assign accept = start && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      addrQ     <= '0;
      cnt       <= '0;
      lastQ     <= '0;
      transQ    <= 1'b0;
      pendValid <= 1'b0;
      pendIdx   <= '0;
      errQ      <= 1'b0;
    end else begin
      pendValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            errQ   <= badAddr;
            transQ <= transIn;
            lastQ  <= CNT_W'(reqRows - 1'b1);
            cnt    <= '0;
            if (badAddr) begin
              state <= ST_DONE;
            end else begin
              state <= ST_FETCH;
              addrQ <= rowAddr;
            end
          end
        end
        ST_FETCH: begin
          pendValid <= 1'b1;
          pendIdx   <= cnt;
          if (cnt == lastQ) state <= ST_DRAIN;
          else              cnt   <= cnt + 1'b1;
        end
        ST_DRAIN: state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign memRdEn   = (state == ST_FETCH);
  assign memRdAddr = addrQ[cnt];
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign err       = errQ;

  always_comb begin
    strobe.clr    = accept && !badAddr;
    strobe.wrEn   = pendValid;
    strobe.trans  = transQ;
    strobe.matIdx = pendIdx[CNT_W-1 -: MAT_IDX_W];
    strobe.rowIdx = pendIdx[ROW_IDX_W-1:0];
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);

  // R8
  aligned_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memRdAddr[ALIGN_BITS-1:0] == '0));

  // R8
  err_fast_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) && err |-> $past(start && !busy));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && busy && !done |=> busy && $stable(transQ));
endmodule

// File: rtl/wmfl_datapath.sv
module wmfl_datapath
  import wmfl_pkg::*;
#(
  parameter int ELEM_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  fragStrobe_t                          strobe,
  input  logic [ROWS*ELEM_W-1:0]               rowData,
  output logic [LANES*MAX_MATS*2*ELEM_W-1:0]   laneRegs
);
  localparam int REG_W = 2*ELEM_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int GRP  = l / 4;
    localparam int QUAD = l % 4;
    for (genvar k = 0; k < MAX_MATS; k++) begin : g_mat
      logic [REG_W-1:0] fragQ;
      logic             hit;

      assign hit = strobe.wrEn && (strobe.matIdx == MAT_IDX_W'(k));

      always_ff @(posedge clk) begin
        if (!rstN || strobe.clr) begin
          fragQ <= '0;
        end else if (hit) begin
          if (!strobe.trans) begin
            if (strobe.rowIdx == ROW_IDX_W'(GRP))
              fragQ <= rowData[2*QUAD*ELEM_W +: REG_W];
          end else if (strobe.rowIdx[ROW_IDX_W-1:1] == (ROW_IDX_W-1)'(QUAD)) begin
            if (strobe.rowIdx[0]) fragQ[REG_W-1:ELEM_W] <= rowData[GRP*ELEM_W +: ELEM_W];
            else                  fragQ[ELEM_W-1:0]     <= rowData[GRP*ELEM_W +: ELEM_W];
          end
        end
      end

      assign laneRegs[(l*MAX_MATS+k)*REG_W +: REG_W] = fragQ;
    end
  end

  // R6
  clr_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.clr && strobe.wrEn));
endmodule

// File: rtl/warp_frag_loader.sv
module warp_frag_loader
  import wmfl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ELEM_W = 16
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   start,
  input  logic [1:0]                             matCount,
  input  logic                                   transpose,
  input  logic [LANES*ADDR_W-1:0]                rowAddr,
  output logic                                   memRdEn,
  output logic [ADDR_W-1:0]                      memRdAddr,
  input  logic [ROWS*ELEM_W-1:0]                 memRdData,
  output logic                                   busy,
  output logic                                   done,
  output logic                                   err,
  output logic [LANES*MAX_MATS*2*ELEM_W-1:0]     laneRegs
);
  fragStrobe_t strobe;

  wmfl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .matCount  (matCount),
    .transIn   (transpose),
    .rowAddr   (rowAddr),
    .memRdEn   (memRdEn),
    .memRdAddr (memRdAddr),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .strobe    (strobe)
  );

  wmfl_datapath #(.ELEM_W(ELEM_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rowData  (memRdData),
    .laneRegs (laneRegs)
  );
endmodule

// File: tb/sim_warp_frag_loader.sv
`timescale 1ns/1ps
module sim_warp_frag_loader;
  localparam int AW = 16;
  localparam int EW = 16;
  localparam int NL = 32;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 start = 1'b0;
  logic [1:0]           matCount = 2'b00;
  logic                 transpose = 1'b0;
  logic [NL*AW-1:0]     rowAddr = '0;
  logic                 memRdEn;
  logic [AW-1:0]        memRdAddr;
  logic [8*EW-1:0]      memRdData = '0;
  logic                 busy, done, err;
  logic [NL*4*2*EW-1:0] laneRegs;

  int vectors = 0;
  int fails = 0;

  logic [AW-1:0] addrs [NL];
  logic [AW-1:0] saved [NL];
  int savedMats = 0;
  logic savedTrans = 1'b0;
  int cyc, reads, orderBad, busyBad;

  always #4 clk = ~clk;

  warp_frag_loader u0 (
    .clk(clk), .rstN(rstN), .start(start), .matCount(matCount),
    .transpose(transpose), .rowAddr(rowAddr), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .busy(busy),
    .done(done), .err(err), .laneRegs(laneRegs)
  );

  function automatic logic [EW-1:0] elemVal(input logic [AW-1:0] a, input int c);
    return {a[11:4], 4'hA, 4'(c)};
  endfunction

  always @(posedge clk) begin
    if (memRdEn)
      for (int c = 0; c < 8; c++) memRdData[c*EW +: EW] <= elemVal(memRdAddr, c);
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic packAddrs();
    for (int j = 0; j < NL; j++) rowAddr[j*AW +: AW] = addrs[j];
  endtask

  task automatic setAddrs(input int seed, input int stride);
    for (int j = 0; j < NL; j++) addrs[j] = AW'(((j*stride + seed) & 255) << 4);
  endtask

  function automatic logic [31:0] expFrag(input int lane, input int k);
    logic [31:0] v;
    if (k >= savedMats) return 32'h0;
    if (!savedTrans) begin
      v[15:0]  = elemVal(saved[8*k + lane/4], 2*(lane%4));
      v[31:16] = elemVal(saved[8*k + lane/4], 2*(lane%4)+1);
    end else begin
      v[15:0]  = elemVal(saved[8*k + 2*(lane%4)],   lane/4);
      v[31:16] = elemVal(saved[8*k + 2*(lane%4)+1], lane/4);
    end
    return v;
  endfunction

  task automatic checkRegs(input string tag);
    int bad = 0;
    logic [31:0] a1 = 0, e1 = 0;
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a = laneRegs[(l*4+k)*32 +: 32];
        logic [31:0] e = expFrag(l, k);
        if (a !== e) begin
          if (bad == 0) begin a1 = a; e1 = e; end
          bad++;
        end
      end
    check(bad == 0, tag, a1, e1);
  endtask

  function automatic int matsOf(input logic [1:0] mc);
    return (mc == 2'b00) ? 1 : (mc == 2'b01) ? 2 : 4;
  endfunction

  task automatic doLoad(input logic [1:0] mc, input bit tr, input bit commit, input bit midStart);
    @(negedge clk);
    matCount = mc; transpose = tr; packAddrs(); start = 1'b1;
    if (commit) begin
      for (int j = 0; j < NL; j++) saved[j] = addrs[j];
      savedMats = matsOf(mc); savedTrans = tr;
    end
    @(negedge clk);
    start = 1'b0; cyc = 0; reads = 0; orderBad = 0; busyBad = 0;
    forever begin
      cyc++;
      if (!busy) busyBad++;
      if (memRdEn) begin
        if (reads < NL && memRdAddr !== saved[reads]) orderBad++;
        reads++;
      end
      if (done || cyc > 100) break;
      if (midStart && cyc == 3) begin
        start = 1'b1; transpose = ~tr; matCount = 2'b00;
        for (int j = 0; j < NL; j++) rowAddr[j*AW +: AW] = AW'((j*5 + 77) << 4);
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic afterDone(input string tag);
    @(negedge clk);
    check(!done, {tag, " R7 done single cycle"}, done, 0);
    check(!busy, {tag, " R11 busy drops"}, busy, 0);
  endtask

  task automatic t_reset();
    int nz = 0;
    check(!busy && !done && !err && !memRdEn, "R1 control idle", {busy, done, err, memRdEn}, 0);
    for (int i = 0; i < NL*4; i++) if (laneRegs[i*32 +: 32] != 0) nz++;
    check(nz == 0, "R1 regs zero", nz, 0);
  endtask

  task automatic t_plain(input logic [1:0] mc, input bit tr, input int seed, input int stride);
    int n = 8*matsOf(mc);
    string tag = $sformatf("mc=%0d tr=%0d", mc, tr);
    setAddrs(seed, stride);
    doLoad(mc, tr, 1'b1, 1'b0);
    check(reads == n, {tag, " R2 read count"}, reads, n);
    check(orderBad == 0, {tag, " R3 read order"}, orderBad, 0);
    check(cyc == n + 2, {tag, " R7 done timing"}, cyc, n + 2);
    check(busyBad == 0, {tag, " R11 busy held"}, busyBad, 0);
    check(!err, {tag, " R8 no error"}, err, 0);
    checkRegs(tr ? {tag, " R5 transposed frags R6"} : {tag, " R4 frags R6"});
    afterDone(tag);
  endtask

  task automatic t_misalign();
    setAddrs(9, 11);
    addrs[13] = addrs[13] | 16'h0008;
    doLoad(2'b01, 1'b0, 1'b0, 1'b0);
    check(cyc == 1, "R8 early done", cyc, 1);
    check(reads == 0, "R8 no reads", reads, 0);
    check(err, "R8 err raised", err, 1);
    checkRegs("R8 regs unchanged");
    afterDone("R8");
    check(err, "R8 err held", err, 1);
    t_plain(2'b00, 1'b0, 50, 3);
    check(!err, "R8 err cleared", err, 0);
  endtask

  task automatic t_unusedLane();
    setAddrs(101, 7);
    addrs[20] = addrs[20] | 16'h0004;
    addrs[31] = addrs[31] | 16'h0001;
    doLoad(2'b01, 1'b1, 1'b1, 1'b0);
    check(!err, "R9 unused lane ignored", err, 0);
    check(reads == 16, "R9 reads", reads, 16);
    checkRegs("R9 regs");
    afterDone("R9");
  endtask

  task automatic t_busyStart();
    setAddrs(33, 13);
    doLoad(2'b10, 1'b0, 1'b1, 1'b1);
    check(reads == 32, "R10 reads", reads, 32);
    check(orderBad == 0, "R10 order", orderBad, 0);
    check(cyc == 34, "R10 timing", cyc, 34);
    checkRegs("R10 regs");
    afterDone("R10");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain(2'b10, 1'b0, 7, 9);
        t_plain(2'b00, 1'b0, 3, 5);
        t_plain(2'b01, 1'b0, 200, 17);
        t_plain(2'b11, 1'b1, 60, 23);
        t_plain(2'b01, 1'b1, 140, 29);
        t_misalign();
        t_unusedLane();
        t_busyStart();
      end
      begin
        repeat (20000) @(negedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule